// File: doc/BRIEF.md
# Pointer Registers with Indirect RAM Access and Program-Table Read

This block holds three byte-wide working registers that are mapped into the data address space: a result register (here called the table-high register), a low pointer and a high pointer. Together the two pointers form a combined address that the block uses in two ways.

The first use is an indirect data access. A read or a write to one pseudo-register address is redirected to data RAM. The low bits of the high pointer choose the RAM bank, and the low pointer chooses the byte within that bank. The second use is a program-memory table read. The full pointer pair addresses one 16-bit ROM word. The block then splits that word: its low byte goes to the accumulator through a load strobe, and its high byte goes into the table-high register.

A CPU datapath drives the register port and the lookup start input. The RAM and the ROM sit outside the block, and both answer one cycle after they are addressed.

Top module: `ptr_lookup_unit`

## Requirements
- R1: After reset, the table-high, low-pointer and high-pointer registers read 00h. `reg_rvalid`, `acc_ld_en` and `lookup_busy` are low until a request arrives.
- R2: The table-high register is at data address 82h, the low pointer at 83h and the high pointer at 84h. All three are read/write. A write updates the register at the clock edge. A read request (`reg_rd` high with `reg_wr` low) produces `reg_rvalid` one cycle later, with the value the register held when the request was sampled. When `reg_rd` and `reg_wr` are high in the same cycle, the write is performed and the read is dropped, so no `reg_rvalid` follows.
- R3: A read of any other address returns 00h with `reg_rvalid`. A write to any other address changes none of the three registers and writes no RAM.
- R4: When `lookup_start` is high and the block is idle, the ROM is addressed in that cycle with {high pointer, low pointer}, truncated to the low `PROG_AW` bits. `lookup_busy` is high for the next cycle. One cycle after that, `acc_ld_en` pulses for one cycle with `acc_data` set to ROM bits 7..0, and the table-high register holds ROM bits 15..8. A start that arrives while busy is ignored.
- R5: If the table read captures its data in the same cycle as a register-port write to 82h, the ROM high byte is what ends up in the table-high register.
- R6: A read or write at address E7h accesses RAM address {high pointer bits 3..0, low pointer}. High-pointer bits 7..4 have no effect on this address. No carry passes from the low pointer into the bank, so bank 1 with low pointer FFh is RAM 1FFh. An indirect read returns the RAM byte one cycle after the request.
- R7: When the indirect address falls in bank 0 with a low pointer of 80h or above (the system-register window), a write at E7h is dropped and a read at E7h returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register-port write request |
| reg_rd | input | 1 | Register-port read request |
| reg_addr | input | 8 | Data-space address of the access |
| reg_wdata | input | 8 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata | output | 8 | Read data |
| ram_addr | output | 12 | Indirect RAM address {bank, byte} |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe; data is expected on the next cycle |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| rom_re | output | 1 | ROM read strobe |
| rom_addr | output | 12 | ROM word address |
| rom_rdata | input | 16 | ROM word, one cycle after `rom_re` |
| lookup_start | input | 1 | Request a table read |
| lookup_busy | output | 1 | Table read is in its capture cycle |
| acc_ld_en | output | 1 | Accumulator load strobe |
| acc_data | output | 8 | Byte to be loaded into the accumulator |

The ports have no back-pressure. Every request is taken in the cycle it is presented, and the register read response and the accumulator load cannot be stalled. The caller spaces table reads at least two cycles apart; a start presented while busy is dropped.

## Verification
The hardest cases to reach from the ports are collisions between the table-read capture cycle and register-port traffic. These are a write to the table-high register that lands exactly in the capture cycle, a pointer write in the same cycle as a start, and a start held high across the busy cycle. Directed sequences place each of these on purpose. A long stretch of random mixed traffic then keeps producing more of them. Pointer values are chosen so that the upper nibble of the high pointer is non-zero and the low pointer sits on both sides of 80h in bank 0. The bank aliasing and the system-window blocking are then visible in what the bench reads back through E7h.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

  localparam logic [7:0] ADDR_TBLHI = 8'h82;
  localparam logic [7:0] ADDR_PLO   = 8'h83;
  localparam logic [7:0] ADDR_PHI   = 8'h84;
  localparam logic [7:0] ADDR_IND   = 8'hE7;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_TBLHI = 3'd1,
    TGT_PLO   = 3'd2,
    TGT_PHI   = 3'd3,
    TGT_IND   = 3'd4
  } tgt_e;

  function automatic tgt_e decode_addr(input logic [7:0] a);
    case (a)
      ADDR_TBLHI: decode_addr = TGT_TBLHI;
      ADDR_PLO:   decode_addr = TGT_PLO;
      ADDR_PHI:   decode_addr = TGT_PHI;
      ADDR_IND:   decode_addr = TGT_IND;
      default:    decode_addr = TGT_NONE;
    endcase
  endfunction

  // slot 0: table-high, slot 1: low pointer, slot 2: high pointer
  function automatic tgt_e slot_tgt(input int s);
    case (s)
      0:       slot_tgt = TGT_TBLHI;
      1:       slot_tgt = TGT_PLO;
      default: slot_tgt = TGT_PHI;
    endcase
  endfunction

endpackage

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  tgt_e          wr_tgt,
  input  logic [DW-1:0] wdata,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_hi,
  output logic [DW-1:0] tblhi_q,
  output logic [DW-1:0] plo_q,
  output logic [DW-1:0] phi_q
);
  localparam int NSLOT = 3;

  logic [DW-1:0] slot_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s == 0) begin : g_tblhi
      // table capture has priority over the register port (R5)
      always_ff @(posedge clk) begin
        if (!rst_n)                                  slot_q[s] <= '0;
        else if (cap_en)                             slot_q[s] <= cap_hi;
        else if (wr_en && wr_tgt == slot_tgt(s))     slot_q[s] <= wdata;
      end
    end else begin : g_ptr
      always_ff @(posedge clk) begin
        if (!rst_n)                                  slot_q[s] <= '0;
        else if (wr_en && wr_tgt == slot_tgt(s))     slot_q[s] <= wdata;
      end
    end
  end

  assign tblhi_q = slot_q[0];
  assign plo_q   = slot_q[1];
  assign phi_q   = slot_q[2];
endmodule

// File: rtl/ptr_indirect.sv
module ptr_indirect #(
  parameter int              DW        = 8,
  parameter int              BANK_BITS = 4,
  parameter int              SYS_BANK  = 0,
  parameter logic [DW-1:0]   SYS_BASE  = 8'h80,
  localparam int             AW        = BANK_BITS + DW
) (
  input  logic [DW-1:0] phi_i,
  input  logic [DW-1:0] plo_i,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic          ram_re,
  output logic [DW-1:0] ram_wdata,
  output logic          blocked
);
  logic [BANK_BITS-1:0] bank;

  // upper pointer bits beyond the bank field are dropped (R6)
  assign bank      = BANK_BITS'(phi_i);
  assign ram_addr  = {bank, plo_i};
  assign blocked   = (bank == BANK_BITS'(SYS_BANK)) && (plo_i >= SYS_BASE);
  assign ram_we    = acc_wr && !blocked;
  assign ram_re    = acc_rd && !blocked;
  assign ram_wdata = wdata;
endmodule

// File: rtl/ptr_table_seq.sv
module ptr_table_seq #(
  parameter int DW      = 8,
  parameter int PROG_AW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   phi_i,
  input  logic [DW-1:0]   plo_i,
  output logic            rom_re,
  output logic [PROG_AW-1:0] rom_addr,
  input  logic [2*DW-1:0] rom_rdata,
  output logic            busy,
  output logic            cap_en,
  output logic [DW-1:0]   cap_hi,
  output logic            acc_ld_en,
  output logic [DW-1:0]   acc_data
);
  logic          busy_q;
  logic          ld_q;
  logic [DW-1:0] lo_q;
  logic          accept;

  assign accept   = start && !busy_q;
  assign rom_re   = accept;
  assign rom_addr = PROG_AW'({phi_i, plo_i});
  assign cap_en   = busy_q;
  assign cap_hi   = rom_rdata[2*DW-1:DW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ld_q   <= 1'b0;
      lo_q   <= '0;
    end else begin
      busy_q <= accept;
      ld_q   <= busy_q;
      if (busy_q) lo_q <= rom_rdata[DW-1:0];
    end
  end

  assign busy      = busy_q;
  assign acc_ld_en = ld_q;
  assign acc_data  = lo_q;
endmodule

// File: rtl/ptr_rdmux.sv
module ptr_rdmux
  import ptr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  tgt_e          rd_tgt,
  input  logic          blocked,
  input  logic [DW-1:0] tblhi_i,
  input  logic [DW-1:0] plo_i,
  input  logic [DW-1:0] phi_i,
  input  logic [DW-1:0] ram_rdata,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  logic          rvalid_q;
  logic          from_ram_q;
  logic [DW-1:0] snap_q;
  logic [DW-1:0] snap_d;

  always_comb begin
    case (rd_tgt)
      TGT_TBLHI: snap_d = tblhi_i;
      TGT_PLO:   snap_d = plo_i;
      TGT_PHI:   snap_d = phi_i;
      default:   snap_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
      snap_q     <= '0;
    end else begin
      rvalid_q   <= rd_fire;
      from_ram_q <= rd_fire && (rd_tgt == TGT_IND) && !blocked;
      if (rd_fire) snap_q <= snap_d;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = from_ram_q ? ram_rdata : snap_q;
endmodule

// File: rtl/ptr_lookup_unit.sv
module ptr_lookup_unit
  import ptr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BANK_BITS = 4,
  parameter int PROG_AW   = 12,
  localparam int RAM_AW   = BANK_BITS + DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [7:0]         reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic               reg_rvalid,
  output logic [DW-1:0]      reg_rdata,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic               ram_we,
  output logic               ram_re,
  output logic [DW-1:0]      ram_wdata,
  input  logic [DW-1:0]      ram_rdata,
  output logic               rom_re,
  output logic [PROG_AW-1:0] rom_addr,
  input  logic [2*DW-1:0]    rom_rdata,
  input  logic               lookup_start,
  output logic               lookup_busy,
  output logic               acc_ld_en,
  output logic [DW-1:0]      acc_data
);
  tgt_e          tgt;
  logic          rd_fire;
  logic          blocked;
  logic          cap_en;
  logic [DW-1:0] cap_hi;
  logic [DW-1:0] tblhi_q, plo_q, phi_q;

  assign tgt     = decode_addr(reg_addr);
  assign rd_fire = reg_rd && !reg_wr;

  ptr_regfile #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_tgt  (tgt),
    .wdata   (reg_wdata),
    .cap_en  (cap_en),
    .cap_hi  (cap_hi),
    .tblhi_q (tblhi_q),
    .plo_q   (plo_q),
    .phi_q   (phi_q)
  );

  ptr_indirect #(.DW(DW), .BANK_BITS(BANK_BITS)) u_ind (
    .phi_i     (phi_q),
    .plo_i     (plo_q),
    .acc_wr    (reg_wr && tgt == TGT_IND),
    .acc_rd    (rd_fire && tgt == TGT_IND),
    .wdata     (reg_wdata),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_wdata (ram_wdata),
    .blocked   (blocked)
  );

  ptr_table_seq #(.DW(DW), .PROG_AW(PROG_AW)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (lookup_start),
    .phi_i     (phi_q),
    .plo_i     (plo_q),
    .rom_re    (rom_re),
    .rom_addr  (rom_addr),
    .rom_rdata (rom_rdata),
    .busy      (lookup_busy),
    .cap_en    (cap_en),
    .cap_hi    (cap_hi),
    .acc_ld_en (acc_ld_en),
    .acc_data  (acc_data)
  );

  ptr_rdmux #(.DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .rd_tgt    (tgt),
    .blocked   (blocked),
    .tblhi_i   (tblhi_q),
    .plo_i     (plo_q),
    .phi_i     (phi_q),
    .ram_rdata (ram_rdata),
    .rvalid    (reg_rvalid),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/ptr_lookup_unit_chk.sv
module ptr_lookup_unit_chk #(
  parameter int DW        = 8,
  parameter int BANK_BITS = 4,
  localparam int RAM_AW   = BANK_BITS + DW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [7:0]        reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              reg_rvalid,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_we,
  input logic [DW-1:0]     ram_wdata,
  input logic              rom_re,
  input logic              lookup_busy,
  input logic              acc_ld_en
);
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> reg_rvalid); // R2
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && !reg_wr) |=> !reg_rvalid); // R2
  AST_FETCH_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re |=> lookup_busy); // R4
  AST_BUSY_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_busy |=> acc_ld_en); // R4
  AST_NO_FETCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_busy |-> !rom_re); // R4
  AST_SYS_WINDOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'hE7 && ram_addr[RAM_AW-1:DW] == '0 && ram_addr[DW-1])
      |-> !ram_we); // R7
  AST_RAM_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (reg_wr && reg_addr == 8'hE7 && ram_wdata == reg_wdata)); // R6
endmodule

bind ptr_lookup_unit ptr_lookup_unit_chk #(.DW(DW), .BANK_BITS(BANK_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rvalid  (reg_rvalid),
  .ram_addr    (ram_addr),
  .ram_we      (ram_we),
  .ram_wdata   (ram_wdata),
  .rom_re      (rom_re),
  .lookup_busy (lookup_busy),
  .acc_ld_en   (acc_ld_en)
);

// File: tb/ptr_lookup_unit_tb_top.sv
module ptr_lookup_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, lookup_start = 1'b0;
  logic [7:0]  reg_addr = 8'h00, reg_wdata = 8'h00;
  logic        reg_rvalid, ram_we, ram_re, rom_re, lookup_busy, acc_ld_en;
  logic [7:0]  reg_rdata, ram_wdata, acc_data;
  logic [7:0]  ram_rdata = 8'h00;
  logic [11:0] ram_addr, rom_addr;
  logic [15:0] rom_rdata = 16'h0000;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  ptr_lookup_unit dut_i (.*);

  function automatic logic [15:0] rom_fn(input logic [11:0] a);
    rom_fn = {a[11:4] + 8'h17, a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h0}};
  endfunction

  // external memories driven by the design's ports
  logic [7:0] phys_mem [int];
  always @(posedge clk) begin
    if (ram_we) phys_mem[int'(ram_addr)] = ram_wdata;
    if (ram_re) ram_rdata <= phys_mem.exists(int'(ram_addr)) ? phys_mem[int'(ram_addr)] : 8'h00;
    if (rom_re) rom_rdata <= rom_fn(rom_addr);
  end

  // behavioural reference model
  logic [7:0] exp_mem [int];
  logic [7:0] m_hi, m_lo, m_ph, m_acc, e_rdata;
  logic [11:0] m_pa;
  bit m_pend, e_rvalid, e_ld, e_busy;

  always @(posedge clk) begin
    int ia;
    bit blk, cap, nxt;
    logic [15:0] w;
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_ph = 0; m_pend = 0;
      e_rvalid = 0; e_ld = 0; e_busy = 0; e_rdata = 0; m_acc = 0;
    end else begin
      ia  = int'(m_ph[3:0]) * 256 + int'(m_lo);
      blk = (m_ph[3:0] == 4'h0) && (m_lo >= 8'h80);
      e_rvalid = reg_rd && !reg_wr;
      if (e_rvalid) begin
        if (reg_addr == 8'h82) e_rdata = m_hi;
        else if (reg_addr == 8'h83) e_rdata = m_lo;
        else if (reg_addr == 8'h84) e_rdata = m_ph;
        else if (reg_addr == 8'hE7) e_rdata = blk ? 8'h00 : (exp_mem.exists(ia) ? exp_mem[ia] : 8'h00);
        else e_rdata = 8'h00;
      end
      cap = m_pend;
      w = rom_fn(m_pa);
      e_ld = cap;
      if (cap) m_acc = w[7:0];
      nxt = 0;
      if (!m_pend && lookup_start) begin
        m_pa = {m_ph[3:0], m_lo};
        nxt = 1;
      end
      if (reg_wr) begin
        if (reg_addr == 8'h82) m_hi = reg_wdata;
        else if (reg_addr == 8'h83) m_lo = reg_wdata;
        else if (reg_addr == 8'h84) m_ph = reg_wdata;
        else if (reg_addr == 8'hE7 && !blk) exp_mem[ia] = reg_wdata;
      end
      if (cap) m_hi = w[15:8];
      m_pend = nxt;
      e_busy = m_pend;
    end
  end

  task automatic compare();
    n_cmp++;
    if (reg_rvalid !== e_rvalid) begin n_bad++;
      $display("FAIL %s rvalid act=%b exp=%b t=%0t", cur_req, reg_rvalid, e_rvalid, $time); end
    if (e_rvalid) begin n_cmp++;
      if (reg_rdata !== e_rdata) begin n_bad++;
        $display("FAIL %s rdata act=%h exp=%h t=%0t", cur_req, reg_rdata, e_rdata, $time); end
    end
    n_cmp++;
    if (acc_ld_en !== e_ld) begin n_bad++;
      $display("FAIL %s acc_ld act=%b exp=%b t=%0t", cur_req, acc_ld_en, e_ld, $time); end
    if (e_ld) begin n_cmp++;
      if (acc_data !== m_acc) begin n_bad++;
        $display("FAIL %s acc_data act=%h exp=%h t=%0t", cur_req, acc_data, m_acc, $time); end
    end
    n_cmp++;
    if (lookup_busy !== e_busy) begin n_bad++;
      $display("FAIL %s busy act=%b exp=%b t=%0t", cur_req, lookup_busy, e_busy, $time); end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (rst_n) compare();
  endtask

  task automatic drive(input bit wr, input bit rd, input logic [7:0] a,
                       input logic [7:0] d, input bit st);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; lookup_start = st;
    tick();
    reg_wr = 0; reg_rd = 0; lookup_start = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d); drive(1, 0, a, d, 0); endtask
  task automatic rd(input logic [7:0] a); drive(0, 1, a, 8'h00, 0); tick(); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    tick(); tick();
    rd(8'h82); rd(8'h83); rd(8'h84);

    cur_req = "R2";
    wr(8'h82, 8'h3C); wr(8'h83, 8'hC3); wr(8'h84, 8'h5E);
    rd(8'h82); rd(8'h83); rd(8'h84);
    drive(1, 1, 8'h83, 8'h11, 0); tick(); rd(8'h83);

    cur_req = "R3";
    wr(8'h85, 8'hFF); wr(8'h81, 8'hEE); rd(8'h85); rd(8'h00);
    rd(8'h82); rd(8'h83); rd(8'h84);

    cur_req = "R6";
    wr(8'h84, 8'hF2); wr(8'h83, 8'h10); wr(8'hE7, 8'h5A);
    wr(8'h84, 8'h02); rd(8'hE7);
    wr(8'h84, 8'h01); wr(8'h83, 8'hFF); wr(8'hE7, 8'h77);
    wr(8'h84, 8'h02); wr(8'h83, 8'h00); rd(8'hE7);
    wr(8'h84, 8'h91); wr(8'h83, 8'hFF); rd(8'hE7);

    cur_req = "R7";
    wr(8'h84, 8'h00); wr(8'h83, 8'h90); wr(8'hE7, 8'hAB); rd(8'hE7);
    wr(8'h84, 8'h10); rd(8'hE7);
    wr(8'h84, 8'h01); wr(8'hE7, 8'hCD); rd(8'hE7);
    wr(8'h84, 8'h00); wr(8'h83, 8'h7F); wr(8'hE7, 8'h42); rd(8'hE7);

    cur_req = "R4";
    wr(8'h84, 8'h03); wr(8'h83, 8'h21); drive(0, 0, 8'h00, 0, 1); tick(); tick(); rd(8'h82);
    wr(8'h84, 8'hFF); wr(8'h83, 8'hFF); drive(0, 0, 8'h00, 0, 1); tick(); tick(); rd(8'h82);
    for (int i = 0; i < 6; i++) drive(0, 0, 8'h00, 0, 1);
    tick(); rd(8'h82);
    drive(1, 0, 8'h84, 8'h0A, 1); tick(); tick();

    cur_req = "R5";
    wr(8'h83, 8'h44);
    drive(0, 0, 8'h00, 0, 1); drive(1, 0, 8'h82, 8'h99, 0); tick(); rd(8'h82);
    drive(0, 0, 8'h00, 0, 1); drive(0, 1, 8'h82, 8'h00, 0); tick(); rd(8'h82);

    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [7:0] a;
      sel = $urandom_range(0, 5);
      case (sel)
        0: a = 8'h82; 1: a = 8'h83; 2: a = 8'h84;
        3, 4: a = 8'hE7; default: a = 8'h86;
      endcase
      drive($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a,
            (a == 8'h84) ? 8'($urandom_range(0, 255) & 8'h13) : 8'($urandom_range(0, 255)),
            $urandom_range(0, 3) == 0);
    end
    tick(); tick();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule